// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Write-Cycle Read Behaviour

This block is a clocked single-port memory. One address serves both reads and writes, and every access happens on the rising clock edge. A build-time parameter decides what the data output shows on a cycle that writes. It can keep its last value, it can show the word being written, or it can show the word that the write replaces.

A 3-bit select input is compared against a 3-bit parameter. The port acts only when the two match and the clock enable is high. Up to eight copies can therefore share one bus, with the upper address bits driving the select lines. An optional output register adds one cycle of read latency. The reset is active high and can be built as synchronous or asynchronous. It clears the output path only; the stored words are kept.

The default geometry is 1024 words of 9 bits, which is 9,216 bits. Other width and depth pairs with the same total are set through the width parameters.

Top module: `spram_wm`

## Requirements
- R1: When `ce` is 1, `cs` equals `CS_MATCH` and `we` is 1, the word on `din` is stored at `addr` on the rising edge.
- R2: When `ce` is 1, `cs` equals `CS_MATCH` and `we` is 0, the read latch takes the word at `addr` on the rising edge. With `OUT_REG`=0, `dout` shows that word from that edge onward, which is one cycle of latency.
- R3: With `WRITE_MODE`=WM_HOLD, a write cycle leaves the read latch, and so `dout`, unchanged.
- R4: With `WRITE_MODE`=WM_PASS, a write cycle loads the read latch with the `din` being written.
- R5: With `WRITE_MODE`=WM_OLD, a write cycle loads the read latch with the word that was at `addr` before that write.
- R6: When `cs` differs from `CS_MATCH`, no word is stored and the read latch holds its value.
- R7: When `ce` is 0, no word is stored, the read latch holds, and the output register holds.
- R8: With `OUT_REG`=1, an output register takes the read latch value on every rising edge where `ce` is 1. `dout` is that register, so a read appears two edges after it is issued.
- R9: A high `rst` clears the read latch and the output register to zero. With `ASYNC_RST`=0 this happens at the next rising edge. With `ASYNC_RST`=1 it happens as soon as `rst` rises.
- R10: Reset does not change any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all accesses occur on its rising edge |
| rst | input | 1 | Active-high reset of the output path |
| ce | input | 1 | Active-high clock enable |
| we | input | 1 | Active-high write enable |
| cs | input | 3 | Select code, compared against `CS_MATCH` |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |

## Verification
Assertions check four rules on every cycle: a deselected or disabled port keeps its read latch, the hold mode never disturbs the output on a write, the pass mode loads exactly the written word, and the output register follows the latch by one enabled edge. Three behaviours are shown only by the bench scenarios. The first is that the replace-old mode returns the prior contents. The second is that writes are really blocked by a select mismatch or a low enable, which the bench proves by reading the contents back. The third covers the reset cases: the asynchronous variant clears its output in the middle of a cycle while the synchronous one waits for the edge, and the stored array survives the reset.

// File: rtl/spram_pkg.sv
package spram_pkg;

  typedef enum logic [1:0] {
    WM_HOLD = 2'd0,
    WM_PASS = 2'd1,
    WM_OLD  = 2'd2
  } writeMode_e;

  typedef struct packed {
    logic portSel;
    logic wrStb;
    logic rdStb;
    logic advReg;
  } ctrlStrobes_t;

endpackage

// File: rtl/spram_ctrl.sv
module spram_ctrl
  import spram_pkg::*;
#(
  parameter logic [2:0] CS_MATCH = 3'b000
) (
  input  logic         ce,
  input  logic         we,
  input  logic [2:0]   cs,
  output ctrlStrobes_t strobes
);

  logic csHit;

  always_comb begin
    csHit           = (cs == CS_MATCH);
    strobes.portSel = ce && csHit;
    strobes.wrStb   = ce && csHit && we;
    strobes.rdStb   = ce && csHit && !we;
    strobes.advReg  = ce;
  end

endmodule

// File: rtl/spram_datapath.sv
module spram_datapath
  import spram_pkg::*;
#(
  parameter int         DATA_W     = 9,
  parameter int         ADDR_W     = 10,
  parameter writeMode_e WRITE_MODE = WM_HOLD,
  parameter bit         OUT_REG    = 1'b1,
  parameter bit         ASYNC_RST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArray [DEPTH];
  logic [DATA_W-1:0] readLatch;
  logic [DATA_W-1:0] latchNext;
  logic              latchLoad;
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk) begin
    if (strobes.wrStb) memArray[addr] <= din;
  end

  always_comb begin
    latchNext = memArray[addr];
    latchLoad = strobes.rdStb;
    if (strobes.wrStb) begin
      case (WRITE_MODE)
        WM_PASS: begin latchNext = din; latchLoad = 1'b1; end
        WM_OLD:  begin latchNext = memArray[addr]; latchLoad = 1'b1; end
        default: begin latchNext = readLatch; latchLoad = 1'b0; end
      endcase
    end
  end

  generate
    if (ASYNC_RST) begin : gAsyncLatch
      always_ff @(posedge clk or posedge rst) begin
        if (rst)            readLatch <= '0;
        else if (latchLoad) readLatch <= latchNext;
      end
    end else begin : gSyncLatch
      always_ff @(posedge clk) begin
        if (rst)            readLatch <= '0;
        else if (latchLoad) readLatch <= latchNext;
      end
    end

    if (OUT_REG) begin : gOutReg
      if (ASYNC_RST) begin : gAsyncOut
        always_ff @(posedge clk or posedge rst) begin
          if (rst)                 outReg <= '0;
          else if (strobes.advReg) outReg <= readLatch;
        end
      end else begin : gSyncOut
        always_ff @(posedge clk) begin
          if (rst)                 outReg <= '0;
          else if (strobes.advReg) outReg <= readLatch;
        end
      end
      assign dout = outReg;

      AST_OUTREG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        strobes.advReg |=> outReg == $past(readLatch)) else $error("outreg"); // R8
    end else begin : gNoOutReg
      assign outReg = '0;
      assign dout   = readLatch;
    end

    if (WRITE_MODE == WM_HOLD) begin : gHoldChk
      AST_HOLD_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        strobes.wrStb |=> $stable(readLatch)) else $error("hold"); // R3
    end
    if (WRITE_MODE == WM_PASS) begin : gPassChk
      AST_PASS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        strobes.wrStb |=> readLatch == $past(din)) else $error("pass"); // R4
    end
  endgenerate

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !strobes.portSel |=> $stable(readLatch)) else $error("idle"); // R6

endmodule

// File: rtl/spram_wm.sv
module spram_wm
  import spram_pkg::*;
#(
  parameter int         DATA_W     = 9,
  parameter int         ADDR_W     = 10,
  parameter writeMode_e WRITE_MODE = WM_HOLD,
  parameter bit         OUT_REG    = 1'b1,
  parameter bit         ASYNC_RST  = 1'b0,
  parameter logic [2:0] CS_MATCH   = 3'b000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              we,
  input  logic [2:0]        cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  ctrlStrobes_t strobes;

  spram_ctrl #(.CS_MATCH(CS_MATCH)) uCtrl (
    .ce(ce), .we(we), .cs(cs), .strobes(strobes)
  );

  spram_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WRITE_MODE(WRITE_MODE),
    .OUT_REG(OUT_REG), .ASYNC_RST(ASYNC_RST)
  ) uData (
    .clk(clk), .rst(rst), .strobes(strobes),
    .addr(addr), .din(din), .dout(dout)
  );

  AST_CE_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ce |-> !strobes.wrStb && !strobes.rdStb) else $error("ce"); // R7

endmodule

// File: tb/spram_wm_test.sv
module spram_wm_test;
  import spram_pkg::*;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, we = 1'b0;
  logic [2:0] cs = 3'b000;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] doutN, doutW, doutR;

  int checks = 0;
  int errors = 0;
  bit rbwValid = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // hold mode, no output register, synchronous reset
  spram_wm #(.DATA_W(DW), .ADDR_W(AW), .WRITE_MODE(WM_HOLD), .OUT_REG(1'b0),
             .ASYNC_RST(1'b0), .CS_MATCH(SEL)) uut (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .cs(cs), .addr(addr), .din(din), .dout(doutN));
  // pass mode, output register, asynchronous reset
  spram_wm #(.DATA_W(DW), .ADDR_W(AW), .WRITE_MODE(WM_PASS), .OUT_REG(1'b1),
             .ASYNC_RST(1'b1), .CS_MATCH(SEL)) uutPass (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .cs(cs), .addr(addr), .din(din), .dout(doutW));
  // replace-old mode, no output register, asynchronous reset
  spram_wm #(.DATA_W(DW), .ADDR_W(AW), .WRITE_MODE(WM_OLD), .OUT_REG(1'b0),
             .ASYNC_RST(1'b1), .CS_MATCH(SEL)) uutOld (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .cs(cs), .addr(addr), .din(din), .dout(doutR));

  // reference model built from the requirements
  logic [DW-1:0] mMem [16];
  logic [DW-1:0] eN = '0, eW = '0, eWreg = '0, eR = '0;
  wire act = ce && (cs == SEL);

  always @(posedge clk) if (act && we) mMem[addr] <= din;
  always @(posedge clk) begin
    if (rst) eN <= '0;
    else if (act && !we) eN <= mMem[addr];
  end
  always @(posedge clk or posedge rst) begin
    if (rst) begin eW <= '0; eWreg <= '0; end
    else begin
      if (act) eW <= we ? din : mMem[addr];
      if (ce) eWreg <= eW;
    end
  end
  always @(posedge clk or posedge rst) begin
    if (rst) eR <= '0;
    else if (act) eR <= mMem[addr];
  end

  task automatic cmp(input string tag, input string inst, input logic [DW-1:0] act_v,
                     input logic [DW-1:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, inst, act_v, exp_v, $time);
    end
  endtask

  task automatic checkAll(input string tN, input string tW, input string tR);
    cmp(tN, "hold", doutN, eN);
    cmp(tW, "pass", doutW, eWreg);
    if (rbwValid) cmp(tR, "old", doutR, eR);
  endtask

  task automatic step(input logic c, input logic [2:0] s, input logic w,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string tN, input string tW, input string tR);
    ce = c; cs = s; we = w; addr = a; din = d;
    @(negedge clk);
    checkAll(tN, tW, tR);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    checkAll("R9", "R9", "R9");
    rst = 1'b0;
    @(negedge clk);
    checkAll("R9", "R9", "R9");

    // fill every address
    for (int a = 0; a < 16; a++)
      step(1, SEL, 1, a[AW-1:0], DW'(a * 13 + 7), "R3", "R4", "R5");
    // read back all words
    rbwValid = 1'b1;
    for (int a = 0; a < 16; a++)
      step(1, SEL, 0, a[AW-1:0], 8'h00, "R2", "R8", "R1");
    step(0, SEL, 0, 0, 0, "R7", "R8", "R7");
    // overwrite: write-cycle behaviour per mode
    for (int a = 0; a < 16; a++)
      step(1, SEL, 1, a[AW-1:0], DW'(a * 29 + 3), "R3", "R4", "R5");
    // back-to-back write then read of same address
    for (int a = 0; a < 16; a += 5) begin
      step(1, SEL, 1, a[AW-1:0], DW'(a * 7 + 100), "R3", "R4", "R5");
      step(1, SEL, 0, a[AW-1:0], 8'h00, "R1", "R8", "R2");
    end
    // blocked writes: select mismatch and clock enable low
    for (int a = 0; a < 16; a += 3) begin
      step(1, SEL ^ 3'b001, 1, a[AW-1:0], 8'hAA, "R6", "R6", "R6");
      step(1, SEL ^ 3'b100, 0, a[AW-1:0], 8'h00, "R6", "R8", "R6");
      step(0, SEL, 1, a[AW-1:0], 8'h55, "R7", "R7", "R7");
    end
    for (int a = 0; a < 16; a++)
      step(1, SEL, 0, a[AW-1:0], 8'h00, "R6", "R7", "R6");
    // mid-cycle reset: asynchronous variants clear at once, synchronous waits
    ce = 1'b0;
    #2 rst = 1'b1;
    #1 checkAll("R9", "R9", "R9");
    @(negedge clk);
    checkAll("R9", "R9", "R9");
    rst = 1'b0;
    @(negedge clk);
    // stored words survive reset
    for (int a = 0; a < 16; a++)
      step(1, SEL, 0, a[AW-1:0], 8'h00, "R10", "R10", "R10");
    step(1, SEL, 0, 0, 0, "R10", "R8", "R10");
    step(1, SEL, 0, 0, 0, "R10", "R8", "R10");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule